// File: doc/BRIEF.md
# Pulse-Width Tag Programming Modulator

This block programs a low-frequency transponder by switching the reader field on and off through one control output. A start request latches a 64-bit data word and a 16-bit checksum. The block then holds the field on for a charge interval and sends a fixed write frame of fourteen bytes. It ends by holding the field on for a programming interval and pulses a completion flag. The checksum is supplied by the caller and is not computed here.

Each bit occupies a cell of fixed length. The cell opens with a field-off gap and closes with a field-on interval that fills out the cell. A long gap means one and a short gap means zero. All intervals are counted in microseconds. The microsecond enable is derived from the clock frequency parameter by a divider that restarts when a frame is accepted.

The controller has five states. IDLE leaves the field on. It moves to CHARGE on a start request (transition "accept"). CHARGE moves to GAP when the charge time runs out ("charged"). GAP moves to MARK when the gap runs out ("gap_end"). MARK moves back to GAP for the next bit ("next_bit"), or to PROG after the last bit ("frame_end"). PROG returns to IDLE when the programming time runs out ("programmed"), and done is raised for that one clock.

Top module: `tagprog_modulator`

## Requirements
- R1: After reset and whenever idle, field_on is 1, busy is 0 and done is 0.
- R2: A start sampled high while idle raises busy in the next cycle. The field then stays on for CHARGE_US microseconds before the first bit.
- R3: A bit of value 1 is sent as ONE_OFF_US microseconds with field_on at 0, followed by CELL_US minus ONE_OFF_US microseconds with field_on at 1.
- R4: A bit of value 0 is sent as ZERO_OFF_US microseconds with field_on at 0, followed by CELL_US minus ZERO_OFF_US microseconds with field_on at 1.
- R5: The frame is fourteen bytes in this order: 0xBB, 0xEB, data[7:0], data[15:8], and so on up to data[63:56], then crc[7:0], crc[15:8], 0x00, 0x03.
- R6: Within each byte, bit 0 is sent first and bit 7 last.
- R7: After the on-interval of the last bit, the field stays on for PROG_US microseconds.
- R8: done is 1 for exactly one clock, in the first idle cycle after the programming time. busy is 0 in that same cycle.
- R9: A start while busy has no effect on the waveform. data and crc are sampled only when a start is accepted, so later changes have no effect.
- R10: One microsecond equals CLK_HZ/1000000 clock cycles, and every interval is a whole number of such units counted from the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send one write frame |
| data | input | 64 | Data word to program, byte 0 in bits 7:0 |
| crc | input | 16 | Checksum sent after the data, low byte first |
| field_on | output | 1 | 1 turns the reader field on, 0 turns it off |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when programming time ends |

## Verification
Let the edge that accepts a start be edge k, and let one microsecond be D cycles. The outputs are decoded from the state register, so busy rises and the charge begins right after edge k. The first gap starts CHARGE_US·D cycles later. Each gap and on-interval then lasts its microsecond count times D cycles. done appears with busy low exactly CHARGE_US·D + 112·CELL_US·D + PROG_US·D cycles after edge k. The bench model expands each frame into one expected value per cycle and compares all three outputs at every falling edge, which is half a cycle from the edge that updates them. It also injects a second start and changes data and crc in the middle of a frame.

// File: rtl/tagprog_pkg.sv
package tagprog_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_CHARGE = 3'd1,
        S_GAP    = 3'd2,
        S_MARK   = 3'd3,
        S_PROG   = 3'd4
    } tp_state_e;

    localparam int unsigned FRAME_BYTES = 14;
    localparam int unsigned FRAME_BITS  = FRAME_BYTES * 8;
    localparam int unsigned IDX_W       = $clog2(FRAME_BITS);

    localparam logic [7:0] HDR_KEY   = 8'hBB;
    localparam logic [7:0] HDR_PASS  = 8'hEB;
    localparam logic [7:0] TAIL_LO   = 8'h00;
    localparam logic [7:0] TAIL_HI   = 8'h03;

endpackage

// File: rtl/tagprog_tick.sv
module tagprog_tick #(
    parameter int unsigned DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (restart || cnt_q == CW'(DIV - 1)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            assign tick = (cnt_q == CW'(DIV - 1)) && !restart;

            // R10
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end else begin : g_pass
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/tagprog_interval.sv
module tagprog_interval #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    assign expire = tick && !clear && (cnt_q == limit - W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (limit != '0) |-> (cnt_q < limit || $changed(limit)));
endmodule

// File: rtl/tagprog_bitsel.sv
module tagprog_bitsel
    import tagprog_pkg::*;
(
    input  logic [IDX_W-1:0] bit_idx,
    input  logic [63:0]      data,
    input  logic [15:0]      crc,
    output logic             bit_val
);
    logic [3:0] byte_no;
    logic [2:0] bit_no;
    logic [7:0] cur_byte;

    assign byte_no = bit_idx[IDX_W-1:3];
    assign bit_no  = bit_idx[2:0];

    always_comb begin
        unique case (byte_no)
            4'd0:    cur_byte = HDR_KEY;
            4'd1:    cur_byte = HDR_PASS;
            4'd10:   cur_byte = crc[7:0];
            4'd11:   cur_byte = crc[15:8];
            4'd12:   cur_byte = TAIL_LO;
            4'd13:   cur_byte = TAIL_HI;
            4'd2, 4'd3, 4'd4, 4'd5,
            4'd6, 4'd7, 4'd8, 4'd9:
                     cur_byte = data[8*(byte_no - 4'd2) +: 8];
            default: cur_byte = 8'h00;
        endcase
    end

    assign bit_val = cur_byte[bit_no];
endmodule

// File: rtl/tagprog_modulator.sv
module tagprog_modulator
    import tagprog_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned CHARGE_US   = 50_000,
    parameter int unsigned PROG_US     = 50_000,
    parameter int unsigned CELL_US     = 2_000,
    parameter int unsigned ONE_OFF_US  = 1_000,
    parameter int unsigned ZERO_OFF_US = 300
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [63:0] data,
    input  logic [15:0] crc,
    output logic        field_on,
    output logic        busy,
    output logic        done
);
    localparam int unsigned DIV   = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
    localparam int unsigned MAX_A = (CHARGE_US > PROG_US) ? CHARGE_US : PROG_US;
    localparam int unsigned MAX_US = (MAX_A > CELL_US) ? MAX_A : CELL_US;
    localparam int unsigned USW   = $clog2(MAX_US + 1);
    localparam logic [USW-1:0] L_CHARGE = USW'(CHARGE_US);
    localparam logic [USW-1:0] L_PROG   = USW'(PROG_US);
    localparam logic [USW-1:0] L_GAP1   = USW'(ONE_OFF_US);
    localparam logic [USW-1:0] L_GAP0   = USW'(ZERO_OFF_US);
    localparam logic [USW-1:0] L_MARK1  = USW'(CELL_US - ONE_OFF_US);
    localparam logic [USW-1:0] L_MARK0  = USW'(CELL_US - ZERO_OFF_US);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    tp_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [63:0]      data_q;
    logic [15:0]      crc_q;
    logic             done_q;
    logic             accept, tick, expire, cur_bit, last_bit;
    logic [USW-1:0]   limit;

    assign accept   = (state_q == S_IDLE) && start;
    assign last_bit = (idx_q == LAST_IDX);

    tagprog_tick #(.DIV(DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .tick    (tick)
    );

    tagprog_interval #(.W(USW)) u_iv (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .tick   (tick),
        .limit  (limit),
        .expire (expire)
    );

    tagprog_bitsel u_sel (
        .bit_idx (idx_q),
        .data    (data_q),
        .crc     (crc_q),
        .bit_val (cur_bit)
    );

    // interval length selected by state
    always_comb begin
        unique case (state_q)
            S_CHARGE: limit = L_CHARGE;
            S_GAP:    limit = cur_bit ? L_GAP1 : L_GAP0;
            S_MARK:   limit = cur_bit ? L_MARK1 : L_MARK0;
            S_PROG:   limit = L_PROG;
            default:  limit = USW'(1);
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start)  state_d = S_CHARGE;              // accept
            S_CHARGE: if (expire) state_d = S_GAP;                 // charged
            S_GAP:    if (expire) state_d = S_MARK;                // gap_end
            S_MARK:   if (expire) state_d = last_bit ? S_PROG      // frame_end
                                                     : S_GAP;      // next_bit
            S_PROG:   if (expire) state_d = S_IDLE;                // programmed
            default:  state_d = S_IDLE;
        endcase
    end

    // state register and frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            data_q  <= '0;
            crc_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == S_PROG) && expire;
            if (accept) begin
                idx_q  <= '0;
                data_q <= data;
                crc_q  <= crc;
            end else if (state_q == S_MARK && expire && !last_bit) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        field_on = (state_q != S_GAP);
        busy     = (state_q != S_IDLE);
        done     = done_q;
    end

    // R1
    idle_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> field_on);
    // R2
    start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(start) && field_on));
    // R5
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST_IDX);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$rose(busy)) |-> ($stable(data_q) && $stable(crc_q)));
endmodule

// File: tb/sim_tagprog_modulator.sv
module sim_tagprog_modulator;
    localparam int CLK_HZ = 4_000_000;
    localparam int D      = CLK_HZ / 1_000_000;
    localparam int CH_US  = 40;
    localparam int PR_US  = 30;
    localparam int CELL   = 20;
    localparam int OFF1   = 10;
    localparam int OFF0   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [63:0] data = '0;
    logic [15:0] crc = '0;
    logic field_on, busy, done;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tagprog_modulator #(
        .CLK_HZ(CLK_HZ), .CHARGE_US(CH_US), .PROG_US(PR_US),
        .CELL_US(CELL), .ONE_OFF_US(OFF1), .ZERO_OFF_US(OFF0)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .data(data), .crc(crc),
        .field_on(field_on), .busy(busy), .done(done)
    );

    bit    exp_f[$];
    string exp_tag[$];

    task automatic check(string tag, bit f, bit b, bit d);
        n_checks++;
        if (field_on !== f || busy !== b || done !== d) begin
            n_fail++;
            $display("FAIL %s t=%0t field/busy/done actual %b%b%b expected %b%b%b",
                     tag, $time, field_on, busy, done, f, b, d);
        end
    endtask

    task automatic push_n(int n, bit v, string tag);
        for (int i = 0; i < n; i++) begin
            exp_f.push_back(v);
            exp_tag.push_back(tag);
        end
    endtask

    // behavioural expansion of one frame into per-cycle field values
    task automatic build(logic [63:0] dv, logic [15:0] cv);
        byte unsigned seq[$];
        exp_f.delete();
        exp_tag.delete();
        seq.push_back(8'hBB);
        seq.push_back(8'hEB);
        for (int b = 0; b < 8; b++) seq.push_back(dv[8*b +: 8]);
        seq.push_back(cv[7:0]);
        seq.push_back(cv[15:8]);
        seq.push_back(8'h00);
        seq.push_back(8'h03);
        push_n(CH_US * D, 1'b1, "R2 charge");
        foreach (seq[i]) begin
            for (int k = 0; k < 8; k++) begin
                if (seq[i][k]) begin
                    push_n(OFF1 * D, 1'b0, "R3 R5 R6 R10 one-gap");
                    push_n((CELL - OFF1) * D, 1'b1, "R3 R5 R6 R10 one-mark");
                end else begin
                    push_n(OFF0 * D, 1'b0, "R4 R5 R6 R10 zero-gap");
                    push_n((CELL - OFF0) * D, 1'b1, "R4 R5 R6 R10 zero-mark");
                end
            end
        end
        push_n(PR_US * D, 1'b1, "R7 program");
    endtask

    // inject: cycle index at which a stray start is driven (-1 for none)
    task automatic run_frame(logic [63:0] dv, logic [15:0] cv, int inject);
        build(dv, cv);
        start = 1'b1;
        data  = dv;
        crc   = cv;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        data  = ~dv;       // R9: changes after acceptance must not matter
        crc   = ~cv;
        foreach (exp_f[i]) begin
            check(exp_tag[i], exp_f[i], 1'b1, 1'b0);
            start = (i == inject) ? 1'b1 : 1'b0;
            @(posedge clk);
            @(negedge clk);
        end
        start = 1'b0;
        check("R8 done pulse", 1'b1, 1'b0, 1'b1);
        @(posedge clk);
        @(negedge clk);
        check("R8 R1 done cleared", 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 idle after reset", 1'b1, 1'b0, 1'b0);

        run_frame(64'h0123_4567_89AB_CDEF, 16'hA55A, -1);
        repeat (3) @(negedge clk);
        check("R1 idle between frames", 1'b1, 1'b0, 1'b0);

        run_frame(64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, -1);
        run_frame(64'h0, 16'h0, -1);
        // R9: stray starts during charge, bits and programming
        run_frame(64'h8000_0000_0000_0001, 16'h1234, 5);
        run_frame(64'hDEAD_BEEF_0F1E_2D3C, 16'h00FF, 4000);
        run_frame(64'h5A5A_A5A5_3C3C_C3C3, 16'h8001, 9200);

        repeat (4) @(negedge clk);
        check("R1 final idle", 1'b1, 1'b0, 1'b0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule